// File: doc/BRIEF.md
# Security Policy Record Fetcher

This block turns a single base address into a complete access-control record for a protected memory region. After a start request it reads consecutive words from a policy RAM through a simple read port. It gathers them into one record: a configuration word with access, size-format, error-response, confidentiality and integrity fields, a wide cipher key, and the address where authentication tags are kept. The whole record is published at once together with a one-cycle valid strobe.

Two record kinds are served. A region record with cryptographic services occupies one configuration word, then the key words with the most significant word first, then one tag-address word (six words in total with the default 128-bit key). A plain local record occupies one word only. For a local record the fetcher returns the access, format and error fields and clears all cryptographic outputs. The fetcher also reduces the two mode bits to a route code that a downstream datapath uses to steer data. What the fields mean for bus checking, and the cipher itself, belong to other blocks.

Top module: `polrec_fetch`

## Requirements
- R1: While and after reset, with no start, `busy_o`, `ram_re_o` and `rec_valid_o` are 0, and every record output is zero.
- R2: A start accepted with `single_i`=0 raises `ram_re_o` for exactly six consecutive cycles, beginning the cycle after the accepting edge. In those cycles it presents `base_i`, `base_i`+1, … `base_i`+5, wrapping modulo 2^ADDR_W.
- R3: A start accepted with `single_i`=1 raises `ram_re_o` for exactly one cycle, with the address `base_i`.
- R4: The first word read is the configuration word. Bits [1:0] give `rec_access_o`, bits [3:2] give `rec_format_o`, bit 4 gives `rec_err_en_o`, bit 5 gives confidentiality and bit 6 gives integrity. Bits 7 and above have no effect.
- R5: In six-word mode, `rec_key_o` equals {word1, word2, word3, word4}, with word1 in bits [127:96]. `rec_tag_o` equals word5.
- R6: In single-word mode, `rec_key_o`, `rec_tag_o`, `rec_conf_o` and `rec_integ_o` are zero, whatever bits 5 and 6 of the word hold.
- R7: `rec_route_o` encodes the mode bits as follows. Both set gives 2'b10 (encrypt and authenticate). Integrity only gives 2'b01 (authenticate only). Neither gives 2'b00 (plaintext). Confidentiality without integrity gives 2'b11 (invalid).
- R8: `rec_valid_o` is a one-cycle pulse. With a one-cycle RAM it is high in the cycle that begins N+1 edges after the accepting edge, where N is 6 or 1.
- R9: A start that arrives while `busy_o` is high causes no read, no valid pulse and no change to the record being fetched.
- R10: The record outputs change only in a cycle where `rec_valid_o` is high, and they hold their values until the next pulse.
- R11: `busy_o` is high from the accepting edge until the edge that raises `rec_valid_o`. A start presented in the valid cycle is accepted, which allows back-to-back fetches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Fetch request, taken when not busy |
| single_i | input | 1 | 1: one-word local record, 0: six-word region record |
| base_i | input | ADDR_W | RAM address of the record's first word |
| busy_o | output | 1 | Fetch in progress |
| ram_re_o | output | 1 | Policy RAM read enable |
| ram_addr_o | output | ADDR_W | Policy RAM read address |
| ram_rdata_i | input | WORD_W | Policy RAM read data, RD_LAT cycles after the address |
| rec_valid_o | output | 1 | One-cycle strobe: a new record is on the outputs |
| rec_access_o | output | 2 | Read/write permission field |
| rec_format_o | output | 2 | Allowed transfer size field |
| rec_err_en_o | output | 1 | Error-response enable |
| rec_conf_o | output | 1 | Confidentiality requested |
| rec_integ_o | output | 1 | Integrity requested |
| rec_route_o | output | 2 | Datapath route code |
| rec_key_o | output | KEY_W | Cipher key |
| rec_tag_o | output | WORD_W | Tag-storage address |

## Verification
On every cycle the checker watches the read port. It confirms that reads appear only while busy, that the first address equals the accepted base and that each following address steps by one. It also confirms that a burst contains six or one reads according to the latched mode. The same checker holds the valid strobe to a single cycle, keeps the record frozen between strobes, confirms that busy is low during the strobe, and verifies that local records carry no cryptographic content. Field placement, key word order, the route code for each mode pair, the exact strobe latency, address wrap at the top of the RAM and the rejection of a start made mid-fetch depend on the RAM contents and the stimulus. Only the bench's scenarios can show these.

// File: rtl/polrec_pkg.sv
package polrec_pkg;

   // Configuration word field positions
   localparam int CFG_ACC_LSB   = 0;
   localparam int CFG_FMT_LSB   = 2;
   localparam int CFG_ERR_BIT   = 4;
   localparam int CFG_CONF_BIT  = 5;
   localparam int CFG_INTEG_BIT = 6;
   localparam int CFG_USED_BITS = 7;

   typedef enum logic [1:0] {
      ROUTE_PLAIN = 2'b00,
      ROUTE_AUTH  = 2'b01,
      ROUTE_SEAL  = 2'b10,
      ROUTE_BAD   = 2'b11
   } route_e;

   function automatic route_e route_of(input logic conf, input logic integ);
      route_e r;
      unique case ({conf, integ})
         2'b11:   r = ROUTE_SEAL;
         2'b01:   r = ROUTE_AUTH;
         2'b00:   r = ROUTE_PLAIN;
         default: r = ROUTE_BAD;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/polrec_addr_gen.sv
module polrec_addr_gen #(
   parameter int ADDR_W       = 10,
   parameter int CNT_W        = 3,
   parameter int CRYPTO_WORDS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              single_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              re_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  idx_o,
   output logic [CNT_W-1:0]  last_idx_o
);

   logic              active_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
         cnt_q    <= '0;
         last_q   <= '0;
      end else if (accept_i) begin
         active_q <= 1'b1;
         addr_q   <= base_i;
         cnt_q    <= '0;
         last_q   <= single_i ? '0 : CNT_W'(CRYPTO_WORDS - 1);
      end else if (active_q) begin
         if (cnt_q == last_q) begin
            active_q <= 1'b0;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
            addr_q <= addr_q + 1'b1;
         end
      end
   end

   assign re_o       = active_q;
   assign addr_o     = addr_q;
   assign idx_o      = cnt_q;
   assign last_idx_o = last_q;

endmodule

// File: rtl/polrec_rd_pipe.sv
module polrec_rd_pipe #(
   parameter int DEPTH = 1,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             vld_o,
   output logic [IDX_W-1:0] idx_o
);

   generate
      if (DEPTH == 0) begin : g_comb
         assign vld_o = vld_i;
         assign idx_o = idx_i;
      end else begin : g_regs
         logic             vld_q [DEPTH];
         logic [IDX_W-1:0] idx_q [DEPTH];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < DEPTH; s++) begin
                  vld_q[s] <= 1'b0;
                  idx_q[s] <= '0;
               end
            end else begin
               vld_q[0] <= vld_i;
               idx_q[0] <= idx_i;
               for (int s = 1; s < DEPTH; s++) begin
                  vld_q[s] <= vld_q[s-1];
                  idx_q[s] <= idx_q[s-1];
               end
            end
         end

         assign vld_o = vld_q[DEPTH-1];
         assign idx_o = idx_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/polrec_assemble.sv
module polrec_assemble
   import polrec_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int KEY_W  = 128,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [CNT_W-1:0]  idx_i,
   input  logic [CNT_W-1:0]  last_idx_i,
   input  logic [WORD_W-1:0] data_i,
   output logic              publish_o,
   output logic              valid_o,
   output logic [1:0]        acc_o,
   output logic [1:0]        fmt_o,
   output logic              err_o,
   output logic              conf_o,
   output logic              integ_o,
   output logic [1:0]        route_o,
   output logic [KEY_W-1:0]  key_o,
   output logic [WORD_W-1:0] tag_o
);

   localparam int KW      = KEY_W / WORD_W;
   localparam int TAG_IDX = KW + 1;

   logic [WORD_W-1:0] cfg_sh, cfg_n;
   logic [WORD_W-1:0] tag_sh, tag_n;
   logic [WORD_W-1:0] key_sh [KW];
   logic [KEY_W-1:0]  key_n;
   logic              single_w;
   logic              conf_w, integ_w;

   assign single_w  = (last_idx_i == '0);
   assign publish_o = cap_i && (idx_i == last_idx_i);

   // Next view of every shadow word, folding in the word arriving now
   always_comb begin
      cfg_n = (cap_i && idx_i == '0) ? data_i : cfg_sh;
      tag_n = (cap_i && idx_i == CNT_W'(TAG_IDX)) ? data_i : tag_sh;
      for (int g = 0; g < KW; g++) begin
         key_n[KEY_W-1-g*WORD_W -: WORD_W] =
            (cap_i && idx_i == CNT_W'(g + 1)) ? data_i : key_sh[g];
      end
   end

   assign conf_w  = single_w ? 1'b0 : cfg_n[CFG_CONF_BIT];
   assign integ_w = single_w ? 1'b0 : cfg_n[CFG_INTEG_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_sh <= '0;
         tag_sh <= '0;
         for (int g = 0; g < KW; g++) key_sh[g] <= '0;
      end else if (cap_i) begin
         cfg_sh <= cfg_n;
         tag_sh <= tag_n;
         for (int g = 0; g < KW; g++) key_sh[g] <= key_n[KEY_W-1-g*WORD_W -: WORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         acc_o   <= '0;
         fmt_o   <= '0;
         err_o   <= 1'b0;
         conf_o  <= 1'b0;
         integ_o <= 1'b0;
         route_o <= ROUTE_PLAIN;
         key_o   <= '0;
         tag_o   <= '0;
      end else begin
         valid_o <= publish_o;
         if (publish_o) begin
            acc_o   <= cfg_n[CFG_ACC_LSB +: 2];
            fmt_o   <= cfg_n[CFG_FMT_LSB +: 2];
            err_o   <= cfg_n[CFG_ERR_BIT];
            conf_o  <= conf_w;
            integ_o <= integ_w;
            route_o <= route_of(conf_w, integ_w);
            key_o   <= single_w ? '0 : key_n;
            tag_o   <= single_w ? '0 : tag_n;
         end
      end
   end

endmodule

// File: rtl/polrec_fetch.sv
module polrec_fetch
   import polrec_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 32,
   parameter int KEY_W  = 128,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              single_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              busy_o,
   output logic              ram_re_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   input  logic [WORD_W-1:0] ram_rdata_i,
   output logic              rec_valid_o,
   output logic [1:0]        rec_access_o,
   output logic [1:0]        rec_format_o,
   output logic              rec_err_en_o,
   output logic              rec_conf_o,
   output logic              rec_integ_o,
   output logic [1:0]        rec_route_o,
   output logic [KEY_W-1:0]  rec_key_o,
   output logic [WORD_W-1:0] rec_tag_o
);

   localparam int KEY_WORDS    = KEY_W / WORD_W;
   localparam int CRYPTO_WORDS = KEY_WORDS + 2;
   localparam int CNT_W        = $clog2(CRYPTO_WORDS);

   generate
      if (WORD_W < CFG_USED_BITS) begin : g_chk_word
         $error("WORD_W too narrow for the configuration fields");
      end
      if (KEY_W % WORD_W != 0 || KEY_W < WORD_W) begin : g_chk_key
         $error("KEY_W must be a non-zero multiple of WORD_W");
      end
      if (ADDR_W < 1) begin : g_chk_addr
         $error("ADDR_W must be at least 1");
      end
      if (RD_LAT < 0) begin : g_chk_lat
         $error("RD_LAT must not be negative");
      end
   endgenerate

   logic             busy_q;
   logic             accept;
   logic [CNT_W-1:0] iss_idx, last_idx, cap_idx;
   logic             cap_vld;
   logic             publish;

   assign accept = start_i && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       busy_q <= 1'b0;
      else if (accept)  busy_q <= 1'b1;
      else if (publish) busy_q <= 1'b0;
   end

   assign busy_o = busy_q;

   polrec_addr_gen #(
      .ADDR_W      (ADDR_W),
      .CNT_W       (CNT_W),
      .CRYPTO_WORDS(CRYPTO_WORDS)
   ) i_addr_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .single_i  (single_i),
      .base_i    (base_i),
      .re_o      (ram_re_o),
      .addr_o    (ram_addr_o),
      .idx_o     (iss_idx),
      .last_idx_o(last_idx)
   );

   polrec_rd_pipe #(
      .DEPTH(RD_LAT),
      .IDX_W(CNT_W)
   ) i_rd_pipe (
      .clk  (clk),
      .rst_n(rst_n),
      .vld_i(ram_re_o),
      .idx_i(iss_idx),
      .vld_o(cap_vld),
      .idx_o(cap_idx)
   );

   polrec_assemble #(
      .WORD_W(WORD_W),
      .KEY_W (KEY_W),
      .CNT_W (CNT_W)
   ) i_assemble (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (cap_vld),
      .idx_i     (cap_idx),
      .last_idx_i(last_idx),
      .data_i    (ram_rdata_i),
      .publish_o (publish),
      .valid_o   (rec_valid_o),
      .acc_o     (rec_access_o),
      .fmt_o     (rec_format_o),
      .err_o     (rec_err_en_o),
      .conf_o    (rec_conf_o),
      .integ_o   (rec_integ_o),
      .route_o   (rec_route_o),
      .key_o     (rec_key_o),
      .tag_o     (rec_tag_o)
   );

endmodule

// File: rtl/polrec_sva.sv
module polrec_sva #(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 32,
   parameter int KEY_W  = 128,
   parameter int RD_LAT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              single_i,
   input logic [ADDR_W-1:0] base_i,
   input logic              busy_o,
   input logic              ram_re_o,
   input logic [ADDR_W-1:0] ram_addr_o,
   input logic [WORD_W-1:0] ram_rdata_i,
   input logic              rec_valid_o,
   input logic [1:0]        rec_access_o,
   input logic [1:0]        rec_format_o,
   input logic              rec_err_en_o,
   input logic              rec_conf_o,
   input logic              rec_integ_o,
   input logic [1:0]        rec_route_o,
   input logic [KEY_W-1:0]  rec_key_o,
   input logic [WORD_W-1:0] rec_tag_o
);

   localparam int CW = KEY_W / WORD_W + 2;

   logic       single_l;
   logic [7:0] rd_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         single_l <= 1'b0;
         rd_cnt   <= '0;
      end else if (start_i && !busy_o) begin
         single_l <= single_i;
         rd_cnt   <= '0;
      end else if (ram_re_o) begin
         rd_cnt <= rd_cnt + 1'b1;
      end
   end

   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !ram_re_o);                                            // R9

   AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_i && !busy_o && rst_n) |-> ram_re_o && ram_addr_o == $past(base_i)); // R2

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re_o && $past(ram_re_o) |-> ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)); // R2

   AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> rd_cnt == (single_l ? 8'd1 : 8'(CW)));              // R3

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |=> !rec_valid_o);                                     // R8

   AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_valid_o |-> $stable(rec_key_o) && $stable(rec_tag_o) && $stable(rec_access_o)
                       && $stable(rec_format_o) && $stable(rec_route_o)); // R10

   AST_LOCAL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o && single_l |-> rec_key_o == '0 && rec_tag_o == '0
                                  && !rec_conf_o && !rec_integ_o);         // R6

   AST_IDLE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid_o |-> !busy_o);                                          // R11

endmodule

bind polrec_fetch polrec_sva #(
   .ADDR_W(ADDR_W),
   .WORD_W(WORD_W),
   .KEY_W (KEY_W),
   .RD_LAT(RD_LAT)
) i_polrec_sva (.*);

// File: tb/test_polrec_fetch.sv
`timescale 1ns/1ps
module test_polrec_fetch;

   localparam int AW = 10;
   localparam int WW = 32;
   localparam int KW = 128;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          single = 1'b0;
   logic [AW-1:0] base = '0;
   logic          busy, ram_re, rec_valid, rec_err, rec_conf, rec_integ;
   logic [AW-1:0] ram_addr;
   logic [WW-1:0] ram_rdata = '0;
   logic [1:0]    rec_acc, rec_fmt, rec_route;
   logic [KW-1:0] rec_key;
   logic [WW-1:0] rec_tag;

   logic [WW-1:0] mem [DEPTH];

   typedef struct {
      logic [1:0]    acc;
      logic [1:0]    fmt;
      logic          err;
      logic          conf;
      logic          integ;
      logic [1:0]    route;
      logic [KW-1:0] key;
      logic [WW-1:0] tag;
      int            vcyc;
   } exp_t;

   exp_t          exp_q[$];
   logic [AW-1:0] addr_q[$];
   int checks = 0, errors = 0, cyc = 0, fetches = 0, valids = 0;
   bit finished = 0, have_rec = 0;
   exp_t last_rec;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(posedge clk) if (ram_re) ram_rdata <= mem[ram_addr];

   polrec_fetch #(.ADDR_W(AW), .WORD_W(WW), .KEY_W(KW), .RD_LAT(1)) i_polrec_fetch (
      .clk(clk), .rst_n(rst_n), .start_i(start), .single_i(single), .base_i(base),
      .busy_o(busy), .ram_re_o(ram_re), .ram_addr_o(ram_addr), .ram_rdata_i(ram_rdata),
      .rec_valid_o(rec_valid), .rec_access_o(rec_acc), .rec_format_o(rec_fmt),
      .rec_err_en_o(rec_err), .rec_conf_o(rec_conf), .rec_integ_o(rec_integ),
      .rec_route_o(rec_route), .rec_key_o(rec_key), .rec_tag_o(rec_tag));

   task automatic chk(input string req, input logic [KW-1:0] act, input logic [KW-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic exp_t mk_exp(input logic [AW-1:0] b, input bit sgl, input int vcyc);
      exp_t e;
      logic [WW-1:0] cfg;
      cfg = mem[b];
      e.acc = cfg[1:0]; e.fmt = cfg[3:2]; e.err = cfg[4];
      if (sgl) begin
         e.conf = 0; e.integ = 0; e.key = '0; e.tag = '0;
      end else begin
         e.conf = cfg[5]; e.integ = cfg[6];
         e.key = {mem[AW'(b + 1)], mem[AW'(b + 2)], mem[AW'(b + 3)], mem[AW'(b + 4)]};
         e.tag = mem[AW'(b + 5)];
      end
      case ({e.conf, e.integ})
         2'b11:   e.route = 2'b10;
         2'b01:   e.route = 2'b01;
         2'b00:   e.route = 2'b00;
         default: e.route = 2'b11;
      endcase
      e.vcyc = vcyc;
      return e;
   endfunction

   // Driver: waits for idle, pushes expectations, pulses start
   task automatic fetch(input logic [AW-1:0] b, input bit sgl, input bit intrude);
      int n;
      @(negedge clk);
      while (busy) @(negedge clk);
      n = sgl ? 1 : 6;
      exp_q.push_back(mk_exp(b, sgl, cyc + n + 2));
      for (int k = 0; k < n; k++) addr_q.push_back(AW'(b + k));
      fetches++;
      start = 1'b1; base = b; single = sgl;
      @(negedge clk);
      start = 1'b0;
      if (intrude) begin
         @(negedge clk);
         start = 1'b1; base = AW'(b + 77); single = 1'b1;   // R9: must be ignored
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (ram_re) begin
            if (addr_q.size() == 0) chk("R9 unexpected read", 1, 0);
            else chk("R2/R3 read address", ram_addr, addr_q.pop_front());
         end
         if (rec_valid) begin
            valids++;
            if (exp_q.size() == 0) chk("R9 unexpected valid", 1, 0);
            else begin
               exp_t e;
               e = exp_q.pop_front();
               chk("R8 valid cycle", cyc, e.vcyc);
               chk("R4 access", rec_acc, e.acc);
               chk("R4 format", rec_fmt, e.fmt);
               chk("R4 error enable", rec_err, e.err);
               chk("R6 conf", rec_conf, e.conf);
               chk("R6 integ", rec_integ, e.integ);
               chk("R7 route", rec_route, e.route);
               chk("R5 key", rec_key, e.key);
               chk("R5 tag", rec_tag, e.tag);
               chk("R11 busy low at strobe", busy, 0);
               last_rec = e; have_rec = 1;
            end
         end else if (have_rec) begin
            chk("R10 key held", rec_key, last_rec.key);
            chk("R10 tag held", rec_tag, last_rec.tag);
            chk("R10 route held", rec_route, last_rec.route);
         end
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = (32'h9E3779B9 * (i + 1)) ^ (i << 11);
      mem[10]   = 32'hFFFF_FF80 | 32'h7B;  // both modes, acc 3, fmt 2, err 1
      mem[100]  = 32'h1234_5600 | 32'h46;  // integrity only
      mem[200]  = 32'hABCD_0080 | 32'h05;  // plaintext
      mem[300]  = 32'h0000_0F00 | 32'h32;  // confidentiality only: invalid
      mem[50]   = 32'hFFFF_FFF0 | 32'h6D;  // local, mode bits set but ignored
      mem[1020] = 32'h0000_0000 | 32'h7F;  // wraps around top of RAM
      mem[600]  = 32'h0000_0000 | 32'h49;
      repeat (5) @(negedge clk);
      chk("R1 busy in reset", busy, 0);
      chk("R1 read in reset", ram_re, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", rec_valid, 0);
      chk("R1 key after reset", rec_key, 0);
      chk("R1 tag after reset", rec_tag, 0);
      chk("R1 route after reset", rec_route, 0);
      fetch(10, 0, 0);
      fetch(100, 0, 0);
      fetch(200, 0, 0);
      fetch(300, 0, 0);
      fetch(50, 1, 0);
      fetch(400, 0, 0);   // R11 back-to-back
      fetch(500, 1, 0);
      fetch(1020, 0, 0);  // R2 wrap
      fetch(600, 0, 1);   // R9 intrusion
      fetch(51, 1, 0);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (10) @(negedge clk);
      chk("R9 no stray reads", addr_q.size(), 0);
      chk("R9 valid count", valids, fetches);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog R8 actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule